// File: doc/BRIEF.md
# Glitch-free clock enable gate

This block passes or blocks whole pulses of one input clock, under the control of an enable input. The enable is sampled at the start of each active phase of the clock. It is then held for the rest of that phase, so a pulse that reaches the output is never shorter or longer than the matching input pulse. Wrong use of the enable can cut a pulse short or add a spike. This gate removes both hazards: it drops a stray enable change that lands inside an active phase.

A static parameter selects which edge is active. In rising mode the active phase is clock High and the output idles Low. This is a latch followed by an AND. In falling mode every clock and output level is mirrored: the active phase is clock Low and the output idles High. This is a latch followed by an OR. The enable is active High in both modes. Source logic must keep the enable steady for a short setup window before each active edge.

Top module: `clk_pulse_gate`

## Requirements
- R1: Rising mode (RISING_EDGE=1): if `en_i` is 1 just before a rising `clk_i` edge, `gclk_o` goes High with that edge and falls with the next falling edge. The output High time is exactly one input High time.
- R2: Rising mode: if `en_i` is 0 just before a rising `clk_i` edge, `gclk_o` stays Low for the whole High phase that follows.
- R3: Any change of `en_i` during the active phase of `clk_i` has no effect on `gclk_o` in that phase.
- R4: During the inactive phase of `clk_i`, `gclk_o` sits at its idle level. The idle level is Low in rising mode and High in falling mode.
- R5: Falling mode (RISING_EDGE=0): if `en_i` is 1 just before a falling `clk_i` edge, `gclk_o` goes Low for exactly that input Low time. If `en_i` is 0, `gclk_o` stays High. The enable is active High.
- R6: While `rst_ni` is 0, the gate is disabled and `gclk_o` holds its idle level in both phases of `clk_i`.
- R7: During the inactive phase, the enable is followed transparently. Only its value just before the active edge counts, so a change that is made and then undone within the inactive phase passes no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be gated |
| rst_ni | input | 1 | Asynchronous reset, active Low; forces the gate disabled |
| en_i | input | 1 | Pulse enable, active High in both modes |
| gclk_o | output | 1 | Gated clock |

## Verification
The hardest case to reach from the ports is an enable change inside the active phase, in the same cycle that the enable level decides the pulse. The bench moves the enable a short time after each active edge, to a value that differs from the one sampled before the edge. It then samples the output after that move, so a leak would show up as a cut or added pulse. Separate monitors measure the width of every output pulse against half the clock period. Both mirrored variants are driven from one clock with separate enables, so that each gets its own active phase.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;

  // Output level while the gate is closed or the clock is in its inactive phase.
  function automatic logic idle_level(input bit rising_edge);
    return rising_edge ? 1'b0 : 1'b1;
  endfunction

  // Clock level that marks the active phase (the phase that is passed through).
  function automatic logic active_level(input bit rising_edge);
    return rising_edge ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/clk_phase_norm.sv
`timescale 1ns/1ps
// Maps the input clock to a normalised phase signal that is High in the
// active phase whatever the selected edge.
module clk_phase_norm #(
  parameter bit RISING_EDGE = 1'b1
) (
  input  logic clk_i,
  output logic act_phase_o
);
  generate
    if (RISING_EDGE) begin : g_rise
      assign act_phase_o = clk_i;
    end else begin : g_fall
      assign act_phase_o = ~clk_i;
    end
  endgenerate
endmodule

// File: rtl/clk_en_latch.sv
`timescale 1ns/1ps
// Level-sensitive enable holder: transparent in the inactive phase,
// closed for the whole active phase.
module clk_en_latch (
  input  logic act_phase_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_q_o
);
  always_latch begin
    if (!rst_ni) begin
      en_q_o <= 1'b0;
    end else if (!act_phase_i) begin
      en_q_o <= en_i;
    end
  end
endmodule

// File: rtl/clk_gate_combine.sv
`timescale 1ns/1ps
// Joins the held enable with the raw clock: AND for rising mode,
// OR with the inverted enable for falling mode.
module clk_gate_combine #(
  parameter bit RISING_EDGE = 1'b1
) (
  input  logic clk_i,
  input  logic en_q_i,
  output logic gclk_o
);
  generate
    if (RISING_EDGE) begin : g_and
      assign gclk_o = clk_i & en_q_i;
    end else begin : g_or
      assign gclk_o = clk_i | ~en_q_i;
    end
  endgenerate
endmodule

// File: rtl/clk_pulse_gate.sv
`timescale 1ns/1ps
module clk_pulse_gate
  import clk_gate_pkg::*;
#(
  parameter bit RISING_EDGE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  localparam logic IDLE_LVL = idle_level(RISING_EDGE);
  localparam logic ACT_LVL  = active_level(RISING_EDGE);

  // Named internal events, brought out for the assertions.
  logic act_phase;   // High during the active phase of clk_i
  logic en_held;     // enable value held by the latch

  clk_phase_norm #(.RISING_EDGE(RISING_EDGE)) u_norm (
    .clk_i       (clk_i),
    .act_phase_o (act_phase)
  );

  clk_en_latch u_latch (
    .act_phase_i (act_phase),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .en_q_o      (en_held)
  );

  clk_gate_combine #(.RISING_EDGE(RISING_EDGE)) u_comb (
    .clk_i  (clk_i),
    .en_q_i (en_held),
    .gclk_o (gclk_o)
  );

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  // Enable as seen at the active edge, captured by an edge flop for checking.
  logic en_at_edge;
  always_ff @(posedge act_phase or negedge rst_ni) begin
    if (!rst_ni) en_at_edge <= 1'b0;
    else         en_at_edge <= en_i;
  end

  // R1, R2, R5: at the end of an active phase the output shows the sampled enable.
  a_r1_pulse_follows_sample: assert property (@(negedge act_phase) disable iff (!rst_ni)
    (gclk_o == ACT_LVL) == en_at_edge);

  // R3: the held enable did not move during the active phase.
  a_r3_hold_in_active: assert property (@(negedge act_phase) disable iff (!rst_ni)
    en_held == en_at_edge);

  // R4: just before an active edge (end of inactive phase) the output is idle.
  a_r4_idle_inactive: assert property (@(posedge act_phase) disable iff (!rst_ni)
    gclk_o == IDLE_LVL);

  // R7: the latch is transparent right up to the active edge.
  a_r7_transparent: assert property (@(posedge act_phase) disable iff (!rst_ni)
    en_held == en_i);

  // R6: in reset even the active phase shows the idle level.
  a_r6_reset_idle: assert property (@(negedge act_phase)
    !rst_ni |-> gclk_o == IDLE_LVL);

endmodule

// File: tb/clk_pulse_gate_bench.sv
`timescale 1ns/1ps
module clk_pulse_gate_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  HALF       = CLK_PERIOD / 2;
  localparam int  N_VEC      = 16;
  // Each entry: {rise_pre, rise_noise, fall_pre, fall_noise}
  localparam logic [3:0] VEC [N_VEC] = '{
    4'b1010, 4'b0101, 4'b1111, 4'b0000, 4'b1001, 4'b0110, 4'b1100, 4'b0011,
    4'b1110, 4'b0001, 4'b1011, 4'b0100, 4'b1101, 4'b0010, 4'b1000, 4'b0111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_r = 1'b0;
  logic en_f = 1'b0;
  logic r_out, f_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  time t_rst = 0;
  time t_r = 0;
  time t_f = 0;

  clk_pulse_gate #(.RISING_EDGE(1'b1)) u_clk_pulse_gate (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_r), .gclk_o(r_out));

  clk_pulse_gate #(.RISING_EDGE(1'b0)) u_clk_pulse_gate_fall (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_f), .gclk_o(f_out));

  initial forever #(HALF) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic chk_w(input string req, input time w);
    n_chk++;
    if (w != HALF) begin
      n_fail++;
      $display("FAIL %s at %0t: pulse width actual=%0t expected=%0d", req, $time, w, HALF);
    end
  endtask

  always @(negedge rst_n) t_rst = $time;
  // R1: every rising-mode output High time is one full input High time.
  always @(posedge r_out) t_r = $time;
  always @(negedge r_out) if (rst_n === 1'b1 && t_r > t_rst) chk_w("R1 width", $time - t_r);
  // R5: every falling-mode output Low time is one full input Low time.
  always @(negedge f_out) t_f = $time;
  always @(posedge f_out) if (rst_n === 1'b1 && t_f > t_rst) chk_w("R5 width", $time - t_f);

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic prev_fa;
    prev_fa = 1'b0;
    // Reset state, R6: enables High but outputs stay idle.
    en_r = 1'b1; en_f = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #3; chk("R6 reset rise idle", r_out, 1'b0);
      chk("R6 reset fall idle", f_out, 1'b1);
      @(negedge clk); #3; chk("R6 reset rise low phase", r_out, 1'b0);
      chk("R6 reset fall active phase", f_out, 1'b1);
    end
    en_r = 1'b0; en_f = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;

    // Vector walk: pre values decide pulses, noise values land in the active phase.
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk); #1;
      if (i > 0) chk("R5 fall pulse", f_out, ~prev_fa);
      #1 en_r = VEC[i][3]; en_f = VEC[i][0];
      #2;
      if (i > 0) chk("R3 fall noise ignored", f_out, ~prev_fa);
      chk("R4 rise idle in low phase", r_out, 1'b0);
      @(posedge clk); #1;
      chk("R4 fall idle in high phase", f_out, 1'b1);
      #1 en_r = VEC[i][2]; en_f = VEC[i][1];
      #1 chk(VEC[i][3] ? "R1 rise pass" : "R2 rise block", r_out, VEC[i][3]);
      #1 chk("R3 rise noise ignored", r_out, VEC[i][3]);
      prev_fa = VEC[i][1];
    end
    @(negedge clk); #1 chk("R5 fall pulse last", f_out, ~prev_fa);

    // R7: enable raised then dropped within the inactive phase passes nothing.
    #1 en_r = 1'b1; #1 en_r = 1'b0;
    @(posedge clk); #3 chk("R7 undone enable blocks", r_out, 1'b0);
    // R7: enable raised late in the inactive phase still counts.
    @(negedge clk); #3 en_r = 1'b1;
    @(posedge clk); #3 chk("R7 late enable passes", r_out, 1'b1);
    // R7 falling: enable toggled within clk High phase and undone.
    #1 en_f = 1'b1; #0.5 en_f = 1'b0;
    @(negedge clk); #3 chk("R7 fall undone enable blocks", f_out, 1'b1);

    // R6: reset mid-run with enables High.
    @(posedge clk); #1 en_f = 1'b1;
    @(negedge clk); #1 rst_n = 1'b0;
    #2 chk("R6 async reset forces fall idle", f_out, 1'b1);
    @(posedge clk); #3 chk("R6 mid-run reset rise idle", r_out, 1'b0);
    @(negedge clk); #3 chk("R6 mid-run reset fall idle", f_out, 1'b1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #3 chk("R5 resumes after reset", f_out, 1'b0);
    @(posedge clk); #3 chk("R1 resumes after reset", r_out, 1'b1);

    @(negedge clk); #1 en_r = 1'b0; en_f = 1'b0;
    @(posedge clk); #3 chk("R2 final block", r_out, 1'b0);
    @(negedge clk); #3 chk("R5 final block", f_out, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule